// File: doc/BRIEF.md
# Acknowledge-Paced Serial Word Link

This block is one end of a point-to-point serial channel between two processors. Each transfer carries one 16-bit word. Each direction allows only a single word to be outstanding. The receiving end signals that it has consumed a word by flipping a dedicated acknowledge wire back to the sender. The sender treats any edge on that wire, rising or falling, as permission to launch its next word.

**Transmit side.** The local host pushes words into a small queue. A serializer takes the head word only while the transmit-ready flag is set. Launching a word clears that flag, and it stays clear until the peer's acknowledge edge arrives.

**Receive side.** A deserializer locks onto a one-cycle frame marker. It collects 16 bits, most significant first, into a holding register and raises a receive-ready flag. Nothing is acknowledged when the word arrives. The acknowledge toggles only when the host actually reads the word, so a slow host simply stalls the peer.

Top module: `ackl_endpoint`

## Requirements
- R1: A frame on the transmit pins is one cycle of `fs_out` high, with `ser_out` low, followed by 16 consecutive cycles carrying the word most significant bit first. `fs_out` is never high for two cycles in a row.
- R2: After reset `tx_ready` is 1, so the first word needs no acknowledge. In the cycle where a frame's marker is on `fs_out`, `tx_ready` is 0.
- R3: While `tx_ready` is 0, no new frame starts, however many words are queued.
- R4: Each transition of `ack_in`, rising or falling, sets `tx_ready` on the third rising clock edge after the change (two synchronizer stages plus the edge detector). Holding `ack_in` at a constant level never sets it.
- R5: The transmit queue holds `FIFO_DEPTH` (default 4) words and sends them in write order. A write while the queue is full is dropped and sets `ovf`, which stays set until reset.
- R6: The receiver starts a word on every `fs_in` pulse and shifts in the next 16 bits of `ser_in`, most significant first. One edge after the last bit, `rd_data` holds the word and `rx_ready` is 1. `ack_out` does not change on arrival.
- R7: A cycle with `rd_en` high while `rx_ready` is 1 clears `rx_ready` and inverts `ack_out` at the same edge.
- R8: `rd_en` while `rx_ready` is 0 leaves `ack_out`, `rx_ready` and `rd_data` unchanged.
- R9: With nothing queued, `fs_out` and `ser_out` stay 0 and `tx_ready` stays 1 for any length of idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host push of a word to transmit |
| wr_data | input | 16 | Word to transmit |
| rd_en | input | 1 | Host read of the received word |
| rd_data | output | 16 | Holding register of the last received word |
| tx_ready | output | 1 | Peer has consumed the previous word |
| rx_ready | output | 1 | Unread received word present |
| ovf | output | 1 | Sticky flag: a write was dropped on a full queue |
| fs_out | output | 1 | Transmit frame marker |
| ser_out | output | 1 | Transmit serial data |
| ack_out | output | 1 | Acknowledge toggle sent to the peer |
| fs_in | input | 1 | Receive frame marker |
| ser_in | input | 1 | Receive serial data |
| ack_in | input | 1 | Acknowledge toggle from the peer |

## Verification
The bench loops the serial pins back and plays the peer on `ack_in`. It goes after the edge cases of pacing:
- **Level instead of edge.** It holds `ack_in` high across a queued word. A design detecting the level would send a second frame immediately.
- **Falling edge.** It acknowledges with a falling edge. A rising-only detector would hang.
- **Acknowledge timing.** It checks that no acknowledge leaves before the host reads. An early acknowledge would let the peer overrun an unread word.
- **Overflow and order.** It overfills the queue. A design that overwrote the tail or reordered words would show a wrong word on the wire, and a missing sticky flag would show up as `ovf` low.
- **Empty reads.** It reads while nothing is pending. A spurious acknowledge toggle there would be caught.

// File: rtl/ackl_pkg.sv
package ackl_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BITCNT_W = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BITCNT_W-1:0] bitcnt_t;

    typedef struct packed {
        logic fs;
        logic dat;
    } ser_pins_t;

    function automatic word_t shift_in(word_t cur, logic b);
        return {cur[WORD_W-2:0], b};
    endfunction

endpackage

// File: rtl/ackl_tx_fifo.sv
module ackl_tx_fifo
    import ackl_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_req,
    input  word_t push_data,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  ovf
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push_req && full) ovf <= 1'b1;
        end
    end

    assert_depth_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> ovf);

endmodule

// File: rtl/ackl_tx_shift.sv
module ackl_tx_shift
    import ackl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  word_t     word,
    output logic      idle,
    output ser_pins_t pins
);
    bitcnt_t left;
    word_t   sh;

    assign idle = (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            sh   <= '0;
            pins <= '0;
        end else if (start) begin
            pins.fs  <= 1'b1;
            pins.dat <= 1'b0;
            sh       <= word;
            left     <= bitcnt_t'(WORD_W);
        end else if (left != '0) begin
            pins.fs  <= 1'b0;
            pins.dat <= sh[WORD_W-1];
            sh       <= sh << 1;
            left     <= left - 1'b1;
        end else begin
            pins <= '0;
        end
    end

    assert_fs_single_R1: assert property (@(posedge clk) disable iff (rst)
        pins.fs |=> !pins.fs);

    assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> idle);

endmodule

// File: rtl/ackl_rx_shift.sv
module ackl_rx_shift
    import ackl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ser_pins_t pins,
    output logic      done,
    output word_t     word
);
    bitcnt_t left;
    word_t   sh;

    assign done = !pins.fs && (left == bitcnt_t'(1));
    assign word = shift_in(sh, pins.dat);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            sh   <= '0;
        end else if (pins.fs) begin
            left <= bitcnt_t'(WORD_W);
        end else if (left != '0) begin
            sh   <= shift_in(sh, pins.dat);
            left <= left - 1'b1;
        end
    end

endmodule

// File: rtl/ackl_ack_edge.sv
module ackl_ack_edge (
    input  logic clk,
    input  logic rst,
    input  logic ack_async,
    output logic edge_seen
);
    logic [2:0] stage;

    assign edge_seen = stage[1] ^ stage[2];

    always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[1:0], ack_async};
    end

endmodule

// File: rtl/ackl_endpoint.sv
module ackl_endpoint
    import ackl_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        tx_ready,
    output logic        rx_ready,
    output logic        ovf,
    output logic        fs_out,
    output logic        ser_out,
    output logic        ack_out,
    input  logic        fs_in,
    input  logic        ser_in,
    input  logic        ack_in
);
    word_t     q_head, rx_word, hold;
    logic      q_empty, tx_idle, launch, ack_edge, rx_done;
    ser_pins_t tx_pins, rx_pins;

    assign launch = tx_ready && !q_empty && tx_idle;

    ackl_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push_req(wr_en), .push_data(wr_data),
        .pop(launch), .head(q_head),
        .empty(q_empty), .ovf(ovf)
    );

    ackl_tx_shift u_txs (
        .clk(clk), .rst(rst),
        .start(launch), .word(q_head),
        .idle(tx_idle), .pins(tx_pins)
    );

    assign rx_pins.fs  = fs_in;
    assign rx_pins.dat = ser_in;

    ackl_rx_shift u_rxs (
        .clk(clk), .rst(rst),
        .pins(rx_pins), .done(rx_done), .word(rx_word)
    );

    ackl_ack_edge u_ack (
        .clk(clk), .rst(rst),
        .ack_async(ack_in), .edge_seen(ack_edge)
    );

    assign fs_out  = tx_pins.fs;
    assign ser_out = tx_pins.dat;
    assign rd_data = hold;

    always_ff @(posedge clk) begin
        if (rst)           tx_ready <= 1'b1;
        else if (launch)   tx_ready <= 1'b0;
        else if (ack_edge) tx_ready <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            rx_ready <= 1'b0;
            ack_out  <= 1'b0;
        end else begin
            if (rx_done) hold <= rx_word;
            if (rx_done)    rx_ready <= 1'b1;
            else if (rd_en) rx_ready <= 1'b0;
            if (rd_en && rx_ready) ack_out <= !ack_out;
        end
    end

    assert_ready_clear_R2: assert property (@(posedge clk) disable iff (rst)
        fs_out |-> !tx_ready);

    assert_ack_sets_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_edge && !launch) |=> tx_ready);

    assert_arrival_loads_R6: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (rx_ready && rd_data == $past(rx_word)));

    assert_ack_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rx_ready) |=> (ack_out != $past(ack_out)) && !rx_ready);

    assert_ack_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && rx_ready) |=> $stable(ack_out));

endmodule

// File: tb/test_ackl_endpoint.sv
module test_ackl_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, ack_in = 1'b0;
    logic [15:0] wr_data = '0, rd_data;
    logic        tx_ready, rx_ready, ovf, fs_out, ser_out, ack_out;

    int n_chk = 0, n_fail = 0, frames = 0, cap_left = 0;
    logic [15:0] cap = '0;
    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ackl_endpoint #(.FIFO_DEPTH(DEPTH)) i_ackl_endpoint (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tx_ready(tx_ready),
        .rx_ready(rx_ready), .ovf(ovf), .fs_out(fs_out), .ser_out(ser_out),
        .ack_out(ack_out), .fs_in(fs_out), .ser_in(ser_out), .ack_in(ack_in)
    );

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] next_bit(logic [15:0] w, logic b);
        return {w[14:0], b};
    endfunction

    // Frame monitor on the transmit pins (R1, R5, R9)
    always @(negedge clk) begin
        if (!rst) begin
            if (cap_left > 0) begin
                cap = next_bit(cap, ser_out);
                cap_left--;
                if (cap_left == 0) begin
                    frames++;
                    if (exp_tx.size() == 0)
                        check(1'b0, "R5 unexpected frame", cap, 16'h0);
                    else begin
                        logic [15:0] e;
                        e = exp_tx.pop_front();
                        check(cap == e, "R1/R5 frame word", cap, e);
                    end
                end
            end else if (fs_out) begin
                check(ser_out == 1'b0, "R1 data low during marker", {15'b0, ser_out}, 16'h0);
                cap_left = 16;
            end else begin
                check(ser_out == 1'b0, "R9 idle line low", {15'b0, ser_out}, 16'h0);
            end
        end
    end

    task automatic wr(input logic [15:0] w, input bit accept);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        if (accept) begin exp_tx.push_back(w); exp_rx.push_back(w); end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rx();
        for (int i = 0; i < 200 && !rx_ready; i++) @(negedge clk);
        check(rx_ready == 1'b1, "R6 word arrival", {15'b0, rx_ready}, 16'h1);
    endtask

    task automatic host_read();
        logic a;
        logic [15:0] e;
        a = ack_out;
        e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 16'hxxxx;
        check(rd_data == e, "R6 holding register", rd_data, e);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check(rx_ready == 1'b0, "R7 ready cleared", {15'b0, rx_ready}, 16'h0);
        check(ack_out == !a, "R7 ack toggled", {15'b0, ack_out}, {15'b0, !a});
    endtask

    task automatic toggle_ack();
        @(negedge clk); ack_in = ~ack_in;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic a;
        logic [15:0] d;
        int f0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset state
        check(tx_ready == 1'b1, "R2 reset tx_ready", {15'b0, tx_ready}, 16'h1);
        check(rx_ready == 1'b0, "R6 reset rx_ready", {15'b0, rx_ready}, 16'h0);
        check(ack_out == 1'b0, "R7 reset ack_out", {15'b0, ack_out}, 16'h0);
        check(ovf == 1'b0, "R5 reset ovf", {15'b0, ovf}, 16'h0);
        check(fs_out == 1'b0, "R9 reset fs_out", {15'b0, fs_out}, 16'h0);

        // First word goes without acknowledge
        wr(16'hA5C3, 1'b1);
        @(negedge clk);
        check(fs_out == 1'b1, "R2 first word launched", {15'b0, fs_out}, 16'h1);
        check(tx_ready == 1'b0, "R2 ready cleared by launch", {15'b0, tx_ready}, 16'h0);
        wait_rx();
        idle_cycles(10);
        check(ack_out == 1'b0, "R6 no ack on arrival", {15'b0, ack_out}, 16'h0);
        host_read();

        // Queued word waits for acknowledge
        wr(16'h0F1E, 1'b1);
        idle_cycles(40);
        check(frames == 1, "R3 no frame while not ready", 16'(frames), 16'd1);
        check(tx_ready == 1'b0, "R3 ready stays clear", {15'b0, tx_ready}, 16'h0);

        // Rising acknowledge edge, exact latency
        toggle_ack();
        @(negedge clk);
        check(tx_ready == 1'b0, "R4 latency edge1", {15'b0, tx_ready}, 16'h0);
        @(negedge clk);
        check(tx_ready == 1'b0, "R4 latency edge2", {15'b0, tx_ready}, 16'h0);
        @(negedge clk);
        check(tx_ready == 1'b1, "R4 ready on edge3", {15'b0, tx_ready}, 16'h1);
        @(negedge clk);
        check(fs_out == 1'b1, "R4 queued word launched", {15'b0, fs_out}, 16'h1);
        wait_rx();
        host_read();

        // Constant high level must not release the next word
        wr(16'h8001, 1'b1);
        idle_cycles(40);
        check(frames == 2, "R4 level has no effect", 16'(frames), 16'd2);
        toggle_ack();   // falling edge
        wait_rx();
        host_read();
        toggle_ack();
        idle_cycles(5);
        check(tx_ready == 1'b1, "R4 falling edge", {15'b0, tx_ready}, 16'h1);

        // Read with nothing pending
        a = ack_out; d = rd_data;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check(ack_out == a, "R8 no ack on empty read", {15'b0, ack_out}, {15'b0, a});
        check(rd_data == d, "R8 data unchanged", rd_data, d);
        check(rx_ready == 1'b0, "R8 ready stays clear", {15'b0, rx_ready}, 16'h0);

        // Long idle
        f0 = frames;
        idle_cycles(200);
        check(frames == f0, "R9 no frame when idle", 16'(frames), 16'(f0));
        check(tx_ready == 1'b1, "R9 ready held", {15'b0, tx_ready}, 16'h1);

        // Overflow and order
        wr(16'h1111, 1'b1);
        for (int i = 0; i < DEPTH; i++) wr(16'h2220 + 16'(i), 1'b1);
        check(ovf == 1'b0, "R5 no ovf at capacity", {15'b0, ovf}, 16'h0);
        wr(16'hDEAD, 1'b0);
        check(ovf == 1'b1, "R5 ovf on full write", {15'b0, ovf}, 16'h1);
        for (int i = 0; i <= DEPTH; i++) begin
            wait_rx();
            host_read();
            toggle_ack();
        end
        idle_cycles(6);
        check(exp_tx.size() == 0, "R5 all queued words sent", 16'(exp_tx.size()), 16'd0);
        check(ovf == 1'b1, "R5 ovf sticky", {15'b0, ovf}, 16'h1);

        // Constrained random bursts with random acknowledge delay
        for (int it = 0; it < 30; it++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wr(16'($urandom), 1'b1);
            for (int k = 0; k < n; k++) begin
                wait_rx();
                host_read();
                idle_cycles(int'($urandom % 6));
                toggle_ack();
            end
            idle_cycles(5);
            check(tx_ready == 1'b1, "R4 ready after burst", {15'b0, tx_ready}, 16'h1);
        end
        check(exp_tx.size() == 0, "R5 random order complete", 16'(exp_tx.size()), 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule